// File: doc/BRIEF.md
# Hamming NAND Sector Parity Generator

This block builds a 24-bit Hamming check code over one 512-byte NAND sector while the sector's bytes stream through it. Each data bit has a bit address, equal to its byte index times eight plus its bit position in the byte. For each of the twelve address bits the block keeps two running parities. One covers the data bits whose address has that bit clear ("even"). The other covers the bits whose address has it set ("odd"). The check code is formed from these twelve even/odd pairs.

Data arrives on a valid/ready input. Each beat carries either one byte (x8 mode) or two bytes (x16 mode). A transfer happens on a rising clock edge where `in_valid` and `in_ready` are both high. `in_ready` depends only on `enable` and `clear`, never on `in_valid`. A source may hold `in_valid` high across any number of cycles with `in_ready` low, and nothing is taken during those cycles. Software or a controller pulses `clear` before each sector and holds `enable` high while the page is transferred.

When the 512th byte has been taken, `done` rises and the code freezes. Beats after that point are still accepted but have no effect until the next clear. The code is presented in two forms: a packed 32-bit result word, and a three-byte spare-area code. In the spare-area code, the upper parity bits of each polarity are interleaved by nibble.

Top module: `hecc_sector_gen`

## Requirements
- R1: After reset, `result_word` and `spare_code` are zero and `done` is low.
- R2: For k = 0..11, parity pair k has an even member and an odd member. The even member is the XOR of every accepted data bit whose bit address (byte index × 8 + bit position) has bit k equal to 0. The odd member is the XOR of the accepted bits where bit k is 1.
- R3: Even members of pairs 0..7 occupy `result_word` bits 0..7, and even members of pairs 8..11 occupy bits 8..11. Odd members of pairs 0..7 occupy bits 16..23, and odd members of pairs 8..11 occupy bits 24..27. Bits 15:12 and 31:28 are always zero.
- R4: `spare_code[7:0]` equals `result_word[7:0]` and `spare_code[15:8]` equals `result_word[23:16]`. In `spare_code[23:16]`, the low nibble holds the even members of pairs 8..11 and the high nibble holds the odd members of pairs 8..11, with pair 8 in the lowest bit of each nibble.
- R5: With `wide` = 0, a beat carries one byte in `in_data[7:0]` and bits 15:8 are ignored. With `wide` = 1, a beat carries two bytes: bits 7:0 are the next byte index and bits 15:8 are the index after it.
- R6: `done` is high from the edge that takes the 512th byte until the next clear. While `done` is high, accepted beats leave the code unchanged. In a two-byte beat that crosses the end of the sector, the byte past the end is dropped.
- R7: While `clear` is high, `in_ready` is low. On the following cycle the code is zero, the byte index restarts at 0, and `done` is low.
- R8: `in_ready` equals `enable` AND NOT `clear`. While `enable` is low, no byte is taken and the code does not change.
- R9: A byte taken on a rising edge is reflected in `result_word` and `spare_code` directly after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| clear | input | 1 | Restart the code for a new sector |
| enable | input | 1 | Allow bytes to be taken |
| wide | input | 1 | 1: two bytes per beat, 0: one byte per beat |
| in_valid | input | 1 | Source offers a beat |
| in_data | input | 16 | Beat data, first byte in bits 7:0 |
| in_ready | output | 1 | Block takes a beat this cycle |
| result_word | output | 32 | Packed parity word |
| spare_code | output | 24 | Three-byte spare-area code, byte 0 in bits 7:0 |
| done | output | 1 | Full sector has been absorbed |

## Verification
Every result is due one edge after its stimulus. A taken beat changes the code and possibly `done` right after that edge, and a clear zeroes them at the edge that ends it. `in_ready` follows `enable` and `clear` within the same cycle. The bench changes inputs just after a rising edge and updates a behavioural bit-address model on that edge. At each falling edge it compares the code, `done` and `in_ready` against the model, so every comparison falls half a cycle after the edge that produced the value. Directed checks with hand-worked codes cover single bits at the first and last addresses, a two-byte beat, the sector boundary, and ignored input.

// File: rtl/hecc_pkg.sv
package hecc_pkg;
  localparam int unsigned BYTE_W    = 8;
  localparam int unsigned BIT_POS_W = 3;
  localparam int unsigned LOW_PAIRS = 8;
  localparam int unsigned LANES     = 2;

  typedef enum logic {
    BUS_X8  = 1'b0,
    BUS_X16 = 1'b1
  } bus_width_e;

  function automatic int unsigned pair_total(input int unsigned sector_bytes);
    return BIT_POS_W + $clog2(sector_bytes);
  endfunction
endpackage

// File: rtl/hecc_lane_parity.sv
module hecc_lane_parity
  import hecc_pkg::*;
#(
  parameter int unsigned IDX_W = 9,
  localparam int unsigned NPAIR = IDX_W + BIT_POS_W
) (
  input  logic [BYTE_W-1:0] byte_i,
  input  logic [IDX_W-1:0]  idx_i,
  input  logic              live_i,
  output logic [NPAIR-1:0]  even_o,
  output logic [NPAIR-1:0]  odd_o
);
  logic row_par;

  always_comb begin
    even_o  = '0;
    odd_o   = '0;
    row_par = ^byte_i;
    if (live_i) begin
      // column parities: address bits inside the byte
      for (int j = 0; j < int'(BIT_POS_W); j++) begin
        for (int i = 0; i < int'(BYTE_W); i++) begin
          if (((i >> j) & 1) == 1) odd_o[j]  = odd_o[j]  ^ byte_i[i];
          else                     even_o[j] = even_o[j] ^ byte_i[i];
        end
      end
      // row parities: address bits from the byte index
      for (int k = 0; k < int'(IDX_W); k++) begin
        if (idx_i[k]) odd_o[BIT_POS_W+k]  = row_par;
        else          even_o[BIT_POS_W+k] = row_par;
      end
    end
  end
endmodule

// File: rtl/hecc_accum.sv
module hecc_accum
  import hecc_pkg::*;
#(
  parameter int unsigned SECTOR_BYTES = 512,
  localparam int unsigned IDX_W = $clog2(SECTOR_BYTES),
  localparam int unsigned CNT_W = $clog2(SECTOR_BYTES + 1),
  localparam int unsigned NPAIR = IDX_W + BIT_POS_W
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     clear,
  input  logic                     enable,
  input  logic                     wide,
  input  logic                     in_valid,
  input  logic [LANES*BYTE_W-1:0]  in_data,
  output logic                     in_ready,
  output logic [NPAIR-1:0]         even_q,
  output logic [NPAIR-1:0]         odd_q,
  output logic                     done
);
  logic [CNT_W-1:0] count_q;
  logic             beat;
  logic [LANES-1:0] lane_live;
  logic [LANES-1:0][NPAIR-1:0] lane_even;
  logic [LANES-1:0][NPAIR-1:0] lane_odd;
  logic [NPAIR-1:0] even_d, odd_d;
  logic [CNT_W-1:0] inc;

  assign in_ready = enable & ~clear;
  assign beat     = in_valid & in_ready;
  assign done     = (count_q == CNT_W'(SECTOR_BYTES));

  for (genvar l = 0; l < int'(LANES); l++) begin : g_lane
    logic [CNT_W-1:0] idx;
    logic             lane_en;
    assign idx     = count_q + CNT_W'(l);
    assign lane_en = (l == 0) ? 1'b1 : (wide == BUS_X16);
    assign lane_live[l] = beat & lane_en & (idx < CNT_W'(SECTOR_BYTES));

    hecc_lane_parity #(.IDX_W(IDX_W)) u_lane (
      .byte_i (in_data[l*BYTE_W +: BYTE_W]),
      .idx_i  (idx[IDX_W-1:0]),
      .live_i (lane_live[l]),
      .even_o (lane_even[l]),
      .odd_o  (lane_odd[l])
    );
  end

  always_comb begin
    even_d = even_q;
    odd_d  = odd_q;
    inc    = '0;
    for (int l = 0; l < int'(LANES); l++) begin
      even_d = even_d ^ lane_even[l];
      odd_d  = odd_d  ^ lane_odd[l];
      if (lane_live[l]) inc = inc + CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count_q <= '0;
      even_q  <= '0;
      odd_q   <= '0;
    end else if (clear) begin
      count_q <= '0;
      even_q  <= '0;
      odd_q   <= '0;
    end else begin
      count_q <= count_q + inc;
      even_q  <= even_d;
      odd_q   <= odd_d;
    end
  end

  AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    count_q <= CNT_W'(SECTOR_BYTES)); // R6
  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!enable && !clear) |=> ($stable(even_q) && $stable(odd_q))); // R8
  AST_FULL_FREEZES: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !clear) |=> ($stable(even_q) && $stable(odd_q) && done)); // R6
  AST_CLEAR_RESTARTS: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (count_q == '0 && even_q == '0 && odd_q == '0)); // R7
endmodule

// File: rtl/hecc_pack.sv
module hecc_pack
  import hecc_pkg::*;
#(
  parameter int unsigned NPAIR = 12,
  localparam int unsigned HI      = NPAIR - LOW_PAIRS,
  localparam int unsigned SPARE_W = 2*LOW_PAIRS + 2*HI
) (
  input  logic [NPAIR-1:0]   even_i,
  input  logic [NPAIR-1:0]   odd_i,
  output logic [31:0]        word_o,
  output logic [SPARE_W-1:0] spare_o
);
  always_comb begin
    word_o = '0;
    word_o[LOW_PAIRS-1:0]     = even_i[LOW_PAIRS-1:0];
    word_o[LOW_PAIRS +: HI]   = even_i[LOW_PAIRS +: HI];
    word_o[16 +: LOW_PAIRS]   = odd_i[LOW_PAIRS-1:0];
    word_o[24 +: HI]          = odd_i[LOW_PAIRS +: HI];
  end

  // spare bytes: even low, odd low, then the interleaved upper nibbles
  assign spare_o = {odd_i[LOW_PAIRS +: HI], even_i[LOW_PAIRS +: HI],
                    odd_i[LOW_PAIRS-1:0],   even_i[LOW_PAIRS-1:0]};
endmodule

// File: rtl/hecc_sector_gen.sv
module hecc_sector_gen
  import hecc_pkg::*;
#(
  parameter int unsigned SECTOR_BYTES = 512
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        clear,
  input  logic        enable,
  input  logic        wide,
  input  logic        in_valid,
  input  logic [15:0] in_data,
  output logic        in_ready,
  output logic [31:0] result_word,
  output logic [2*$clog2(SECTOR_BYTES)+2*BIT_POS_W-1:0] spare_code,
  output logic        done
);
  localparam int unsigned NPAIR = pair_total(SECTOR_BYTES);

  logic [NPAIR-1:0] even_q, odd_q;

  hecc_accum #(.SECTOR_BYTES(SECTOR_BYTES)) u_accum (
    .clk      (clk),
    .rst_n    (rst_n),
    .clear    (clear),
    .enable   (enable),
    .wide     (wide),
    .in_valid (in_valid),
    .in_data  (in_data),
    .in_ready (in_ready),
    .even_q   (even_q),
    .odd_q    (odd_q),
    .done     (done)
  );

  hecc_pack #(.NPAIR(NPAIR)) u_pack (
    .even_i  (even_q),
    .odd_i   (odd_q),
    .word_o  (result_word),
    .spare_o (spare_code)
  );

  AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !clear) |=> done); // R6
  AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (result_word == 32'd0 && !done)); // R7
  AST_NO_READY_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
    (!enable || clear) |-> !in_ready); // R8
  AST_WORD_STABLE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_valid && !clear) |=> $stable(result_word)); // R9
endmodule

// File: tb/hecc_sector_gen_bench.sv
module hecc_sector_gen_bench;
  localparam int SB = 512;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        clear = 1'b0;
  logic        enable = 1'b0;
  logic        wide = 1'b0;
  logic        in_valid = 1'b0;
  logic [15:0] in_data = '0;
  logic        in_ready;
  logic [31:0] result_word;
  logic [23:0] spare_code;
  logic        done;

  int checks = 0;
  int fails = 0;
  int cyc = 0;

  int m_even[12];
  int m_odd[12];
  int m_count = 0;

  hecc_sector_gen u_hecc_sector_gen (
    .clk(clk), .rst_n(rst_n), .clear(clear), .enable(enable), .wide(wide),
    .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready),
    .result_word(result_word), .spare_code(spare_code), .done(done)
  );

  always #5 clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h at cycle %0d", req, act, exp, cyc);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  // behavioural model: walk every set bit by its bit address
  function automatic void model_byte(input int idx, input logic [7:0] b);
    for (int bt = 0; bt < 8; bt++) begin
      if (b[bt]) begin
        int addr;
        addr = idx * 8 + bt;
        for (int p = 0; p < 12; p++) begin
          if (((addr >> p) & 1) == 1) m_odd[p] ^= 1;
          else                        m_even[p] ^= 1;
        end
      end
    end
  endfunction

  function automatic logic [31:0] exp_word();
    logic [31:0] w;
    w = '0;
    for (int i = 0; i < 8; i++) begin
      w[i]      = m_even[i][0];
      w[16 + i] = m_odd[i][0];
    end
    for (int i = 0; i < 4; i++) begin
      w[8 + i]  = m_even[8 + i][0];
      w[24 + i] = m_odd[8 + i][0];
    end
    return w;
  endfunction

  always @(posedge clk) begin
    cyc++;
    if (!rst_n || clear) begin
      for (int p = 0; p < 12; p++) begin m_even[p] = 0; m_odd[p] = 0; end
      m_count = 0;
    end else if (enable && in_valid) begin
      if (m_count < SB) begin model_byte(m_count, in_data[7:0]); m_count++; end
      if (wide && m_count < SB) begin model_byte(m_count, in_data[15:8]); m_count++; end
    end
    if (cyc > 150000) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired");
      summary();
    end
  end

  // per-cycle comparison, half a cycle after each edge
  always @(negedge clk) begin
    if (rst_n) begin
      logic [31:0] w;
      w = exp_word();
      chk("R2 R3 word", result_word, w);
      chk("R4 spare", {8'd0, spare_code}, {8'd0, w[27:24], w[11:8], w[23:16], w[7:0]});
      chk("R6 done", {31'd0, done}, {31'd0, m_count == SB});
      chk("R8 ready", {31'd0, in_ready}, {31'd0, enable && !clear});
    end
  end

  task automatic send(input logic v, input logic [15:0] d);
    @(posedge clk); #1;
    in_valid = v;
    in_data  = d;
  endtask

  task automatic do_clear();
    @(posedge clk); #1;
    clear = 1'b1; in_valid = 1'b1; in_data = 16'hFFFF;
    @(posedge clk); #1;
    clear = 1'b0; in_valid = 1'b0;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    chk("R1 word", result_word, 32'd0);
    chk("R1 spare", {8'd0, spare_code}, 32'd0);
    chk("R1 done", {31'd0, done}, 32'd0);

    enable = 1'b1;
    do_clear();
    @(negedge clk);
    chk("R7 clear taken nothing", result_word, 32'd0);

    // first bit address 0: all even members
    send(1'b1, 16'hAA01);
    send(1'b0, 16'h0000);
    @(negedge clk);
    chk("R2 R9 addr0 word", result_word, 32'h00000FFF);
    chk("R4 addr0 spare", {8'd0, spare_code}, 32'h000F00FF);

    // stall with valid high and enable low
    @(posedge clk); #1; enable = 1'b0; in_valid = 1'b1; in_data = 16'h00FF;
    repeat (4) @(posedge clk);
    #1 enable = 1'b1; in_valid = 1'b0;
    @(negedge clk);
    chk("R8 disabled no effect", result_word, 32'h00000FFF);

    for (int i = 1; i < 511; i++) send(1'b1, 16'h5500);
    send(1'b1, 16'h0080);
    send(1'b0, 16'h0000);
    @(negedge clk);
    chk("R2 last addr word", result_word, 32'h0FFF0FFF);
    chk("R4 last addr spare", {8'd0, spare_code}, 32'h00FFFFFF);
    chk("R6 done at 512", {31'd0, done}, 32'd1);

    for (int i = 0; i < 5; i++) send(1'b1, 16'hFFFF);
    send(1'b0, 16'h0000);
    @(negedge clk);
    chk("R6 ignored after done", result_word, 32'h0FFF0FFF);

    do_clear();
    @(negedge clk);
    chk("R7 cleared word", result_word, 32'd0);
    chk("R7 cleared done", {31'd0, done}, 32'd0);

    // two-byte beat: byte index 1 bit 0 -> address 8
    wide = 1'b1;
    send(1'b1, 16'h0100);
    send(1'b0, 16'h0000);
    @(negedge clk);
    chk("R5 wide beat word", result_word, 32'h00080FF7);

    // random x8 sector with gaps, upper byte noise
    do_clear();
    wide = 1'b0;
    while (m_count < SB) begin
      @(posedge clk); #1;
      in_valid = ($urandom % 4) != 0;
      enable   = ($urandom % 8) != 0;
      in_data  = 16'($urandom);
    end
    #1 in_valid = 1'b0; enable = 1'b1;
    @(negedge clk);
    chk("R5 R6 random x8 done", {31'd0, done}, 32'd1);

    // random x16 sector
    do_clear();
    wide = 1'b1;
    while (m_count < SB) begin
      @(posedge clk); #1;
      in_valid = ($urandom % 3) != 0;
      in_data  = 16'($urandom);
    end
    #1 in_valid = 1'b0;
    @(negedge clk);
    chk("R5 random x16 done", {31'd0, done}, 32'd1);

    // 511 bytes narrow, then a two-byte beat straddling the end
    do_clear();
    wide = 1'b0;
    for (int i = 0; i < 511; i++) send(1'b1, 16'($urandom));
    @(posedge clk); #1; wide = 1'b1; in_valid = 1'b1; in_data = 16'hC3A5;
    send(1'b0, 16'h0000);
    @(negedge clk);
    chk("R6 straddle done", {31'd0, done}, 32'd1);

    repeat (3) @(posedge clk);
    summary();
  end
endmodule